// File: doc/BRIEF.md
# Serial Configuration Register Port

This block receives configuration writes over a three-line serial link (an active-low select, a serial clock and a data line) and holds the results in a small file of write-only 10-bit registers. A host lowers select, clocks 16 bits in, and raises select again. Only then, and only if exactly 16 bits arrived before the release, is the frame decoded and written.

All three serial lines are brought into the system clock domain through synchronizer chains. Edges of the synchronized serial clock are detected there, so the system clock must run several times faster than the serial clock. Every committed frame also raises a one-cycle write strobe, which a downstream sequencer uses to restart its own timing.

Top module: `cfg_serial_port`

## Requirements
- R1: While select is low, a bit is taken from the data line at each rising serial-clock edge. Frame bit 0 arrives first. Bits 1:0 are the operation code. Bits 5:2 are the address, with address bit 0 in frame bit 2. Bits 15:6 are the data, with data bit 0 in frame bit 6.
- R2: A frame is committed only when select rises. The register write and the strobe become visible at the third system-clock edge after select is seen high, and never before select has risen.
- R3: A frame with fewer than 16 bits when select rises writes nothing and produces no strobe.
- R4: Bits after the 16th in one select window are ignored. The frame is committed from its first 16 bits.
- R5: The operation-code bits have no effect on what is written.
- R6: Address map, where the address value is (a3 a2 a1 a0): mode-A = 0, mode-B = 8, mode-C = 4, gain = 12, black target = 2, test-A = 1, test-B = 9. A committed frame replaces the addressed register with its 10 data bits.
- R7: A committed frame to any other address changes no register but still produces the strobe.
- R8: Bits 5:0 of test-A and bits 4:0 of test-B always read 0, whatever data is written.
- R9: An asynchronous active-low reset sets mode-A to 0x008, black target to 0x040 and every other register to 0. It also abandons any partial frame.
- R10: Each committed frame produces exactly one strobe, one system-clock cycle wide.
- R11: Register outputs change only in a cycle where the strobe is high, or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data |
| mode1Reg | output | 10 | Mode-A register (address 0) |
| mode2Reg | output | 10 | Mode-B register (address 8) |
| mode3Reg | output | 10 | Mode-C register (address 4) |
| gainReg | output | 10 | Gain register (address 12) |
| blackReg | output | 10 | Black target register (address 2) |
| test1Reg | output | 10 | Test-A register (address 1) |
| test2Reg | output | 10 | Test-B register (address 9) |
| wrStrobe | output | 1 | One-cycle pulse for each committed frame |

## Verification
Frames are sent to every defined address with varied data and operation codes. Distinct data patterns show that the address and data fields are decoded from the correct bit positions, and varying the operation code shows that it has no effect. Short frames (0, 1 and 15 bits) and an over-long 20-bit frame separate exact-length commit from last-clock commit and from overrun handling. Writes to undefined addresses and all-ones writes to the test registers show that unmapped writes are dropped and that the test-register masks hold. A reset in the middle of a frame shows that partial state is discarded.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int DATA_W   = 10;
  localparam int ADDR_W   = 4;
  localparam int OP_W     = 2;
  localparam int FRAME_W  = OP_W + ADDR_W + DATA_W;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam int IDX_W    = $clog2(FRAME_W);
  localparam int NUM_REGS = 7;

  // register slots: mode-A, mode-B, mode-C, gain, black, test-A, test-B
  localparam logic [ADDR_W-1:0] REG_ADDR [NUM_REGS] =
    '{4'd0, 4'd8, 4'd4, 4'd12, 4'd2, 4'd1, 4'd9};
  localparam logic [DATA_W-1:0] REG_RESET [NUM_REGS] =
    '{10'h008, 10'h000, 10'h000, 10'h000, 10'h040, 10'h000, 10'h000};
  localparam logic [DATA_W-1:0] REG_WMASK [NUM_REGS] =
    '{10'h3FF, 10'h3FF, 10'h3FF, 10'h3FF, 10'h3FF, 10'h3C0, 10'h3E0};

  typedef struct packed {
    logic             shiftEn;
    logic [CNT_W-1:0] bitIdx;
    logic             commit;
  } ctrlStrobe_t;
endpackage

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
  import cfgp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        selN,
  input  logic        sclk,
  input  logic        sdi,
  output ctrlStrobe_t strb,
  output logic        sdiSync
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

  logic [SYNC_STAGES-1:0] selSh, sclkSh, sdiSh;
  logic selPrev, sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic selNow, sclkNow, selRise, sclkRise, roomLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selSh    <= '1;
      sclkSh   <= '0;
      sdiSh    <= '0;
      selPrev  <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      selSh    <= {selSh[SYNC_STAGES-2:0], selN};
      sclkSh   <= {sclkSh[SYNC_STAGES-2:0], sclk};
      sdiSh    <= {sdiSh[SYNC_STAGES-2:0], sdi};
      selPrev  <= selNow;
      sclkPrev <= sclkNow;
    end
  end

  assign selNow   = selSh[SYNC_STAGES-1];
  assign sclkNow  = sclkSh[SYNC_STAGES-1];
  assign sdiSync  = sdiSh[SYNC_STAGES-1];
  assign selRise  = selNow & ~selPrev;
  assign sclkRise = sclkNow & ~sclkPrev;
  assign roomLeft = (bitCnt < FULL_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          bitCnt <= '0;
    else if (selNow)                    bitCnt <= '0;
    else if (sclkRise && roomLeft)      bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strb.shiftEn = !selNow && sclkRise && roomLeft;
    strb.bitIdx  = bitCnt;
    strb.commit  = selRise && (bitCnt == FULL_CNT);
  end
endmodule

// File: rtl/cfgp_datapath.sv
module cfgp_datapath
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic              sdiBit,
  output logic [DATA_W-1:0] regQ [NUM_REGS],
  output logic              wrStrobe
);
  logic [FRAME_W-1:0] frameQ;
  logic [ADDR_W-1:0]  frameAddr;
  logic [DATA_W-1:0]  frameData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ   <= '0;
      wrStrobe <= 1'b0;
    end else begin
      if (strb.shiftEn) frameQ[strb.bitIdx[IDX_W-1:0]] <= sdiBit;
      wrStrobe <= strb.commit;
    end
  end

  assign frameAddr = frameQ[OP_W +: ADDR_W];
  assign frameData = frameQ[OP_W+ADDR_W +: DATA_W];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regQ[k] <= REG_RESET[k];
      else if (strb.commit && frameAddr == REG_ADDR[k])
        regQ[k] <= frameData & REG_WMASK[k];
    end
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              sclk,
  input  logic              sdi,
  output logic [DATA_W-1:0] mode1Reg,
  output logic [DATA_W-1:0] mode2Reg,
  output logic [DATA_W-1:0] mode3Reg,
  output logic [DATA_W-1:0] gainReg,
  output logic [DATA_W-1:0] blackReg,
  output logic [DATA_W-1:0] test1Reg,
  output logic [DATA_W-1:0] test2Reg,
  output logic              wrStrobe
);
  ctrlStrobe_t       strb;
  logic              sdiSync;
  logic [DATA_W-1:0] regQ [NUM_REGS];

  cfgp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdi(sdi),
    .strb(strb), .sdiSync(sdiSync)
  );

  cfgp_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sdiBit(sdiSync),
    .regQ(regQ), .wrStrobe(wrStrobe)
  );

  assign mode1Reg = regQ[0];
  assign mode2Reg = regQ[1];
  assign mode3Reg = regQ[2];
  assign gainReg  = regQ[3];
  assign blackReg = regQ[4];
  assign test1Reg = regQ[5];
  assign test2Reg = regQ[6];
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk
  import cfgp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              selN,
  input logic              wrStrobe,
  input logic [DATA_W-1:0] mode1Reg,
  input logic [DATA_W-1:0] mode2Reg,
  input logic [DATA_W-1:0] mode3Reg,
  input logic [DATA_W-1:0] gainReg,
  input logic [DATA_W-1:0] blackReg,
  input logic [DATA_W-1:0] test1Reg,
  input logic [DATA_W-1:0] test2Reg
);
  logic [NUM_REGS*DATA_W-1:0] allRegs;
  assign allRegs = {mode1Reg, mode2Reg, mode3Reg, gainReg, blackReg, test1Reg, test2Reg};

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe); // R10
  AST_REGS_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(allRegs) |-> wrStrobe); // R11
  AST_STROBE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> $past(selN, 2)); // R2
  AST_TESTA_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    test1Reg[5:0] == 6'd0); // R8
  AST_TESTB_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    test2Reg[4:0] == 5'd0); // R8
endmodule

bind cfg_serial_port cfgp_chk chk_i (
  .clk(clk), .rstN(rstN), .selN(selN), .wrStrobe(wrStrobe),
  .mode1Reg(mode1Reg), .mode2Reg(mode2Reg), .mode3Reg(mode3Reg),
  .gainReg(gainReg), .blackReg(blackReg), .test1Reg(test1Reg), .test2Reg(test2Reg)
);

// File: tb/cfg_serial_port_tb_top.sv
module cfg_serial_port_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [9:0] mode1Reg, mode2Reg, mode3Reg, gainReg, blackReg, test1Reg, test2Reg;
  logic wrStrobe;
  int nTests = 0, nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cfg_serial_port dut_i (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdi(sdi),
    .mode1Reg(mode1Reg), .mode2Reg(mode2Reg), .mode3Reg(mode3Reg),
    .gainReg(gainReg), .blackReg(blackReg), .test1Reg(test1Reg),
    .test2Reg(test2Reg), .wrStrobe(wrStrobe)
  );

  logic [9:0] outs [7];
  always_comb begin
    outs[0] = mode1Reg; outs[1] = mode2Reg; outs[2] = mode3Reg; outs[3] = gainReg;
    outs[4] = blackReg; outs[5] = test1Reg; outs[6] = test2Reg;
  end

  // expected model built from R6, R8, R9
  logic [9:0] expReg [7];
  localparam logic [3:0] MAP_ADDR [7] = '{4'd0, 4'd8, 4'd4, 4'd12, 4'd2, 4'd1, 4'd9};
  localparam logic [9:0] MAP_MASK [7] = '{10'h3FF, 10'h3FF, 10'h3FF, 10'h3FF, 10'h3FF, 10'h3C0, 10'h3E0};

  function automatic int slotOf(logic [3:0] a);
    for (int k = 0; k < 7; k++) if (MAP_ADDR[k] == a) return k;
    return -1;
  endfunction

  task automatic setDefaults();
    for (int k = 0; k < 7; k++) expReg[k] = 10'h000;
    expReg[0] = 10'h008; // R9
    expReg[4] = 10'h040; // R9
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkRegs(string req);
    int bad = 0;
    for (int k = 0; k < 7; k++) begin
      if (outs[k] !== expReg[k]) begin
        bad++;
        $display("FAIL %s: reg slot %0d actual %h expected %h", req, k, outs[k], expReg[k]);
      end
    end
    nTests++;
    if (bad != 0) nFail++;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // drives n bits; bits beyond 16 are sent as ones
  task automatic shiftBits(logic [15:0] f, int n);
    for (int i = 0; i < n; i++) begin
      sdi  = (i < 16) ? f[i] : 1'b1;
      sclk = 1'b0;
      waitCyc(3);
      sclk = 1'b1;
      waitCyc(3);
    end
    sclk = 1'b0;
    waitCyc(3);
  endtask

  // vector: {nbits[4:0], data[9:0], addr[3:0], op[1:0]}
  localparam int NVEC = 14;
  localparam logic [20:0] VEC [NVEC] = '{
    {5'd16, 10'h155, 4'd0,  2'b00},
    {5'd16, 10'h2AA, 4'd8,  2'b01},
    {5'd16, 10'h03C, 4'd4,  2'b10},
    {5'd16, 10'h1FF, 4'd12, 2'b11},
    {5'd16, 10'h07F, 4'd2,  2'b00},
    {5'd16, 10'h3FF, 4'd1,  2'b00},
    {5'd16, 10'h3FF, 4'd9,  2'b10},
    {5'd15, 10'h123, 4'd0,  2'b00},
    {5'd0,  10'h3FF, 4'd12, 2'b00},
    {5'd16, 10'h3FF, 4'd3,  2'b00},
    {5'd16, 10'h3FF, 4'd15, 2'b11},
    {5'd20, 10'h001, 4'd12, 2'b00},
    {5'd16, 10'h200, 4'd0,  2'b11},
    {5'd1,  10'h3FF, 4'd8,  2'b01}
  };

  initial begin
    setDefaults();
    waitCyc(3);
    chkRegs("R9 reset defaults");
    chk("R9 strobe low in reset", {15'd0, wrStrobe}, 16'd0);
    rstN = 1'b1;
    waitCyc(3);
    chkRegs("R9 defaults after release");

    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] fr;
      int nb, slot;
      bit commit;
      string tag;
      fr   = VEC[v][15:0];
      nb   = int'(VEC[v][20:16]);
      slot = slotOf(fr[5:2]);
      commit = (nb >= 16);
      if (nb < 16)                    tag = "R3 short frame dropped";
      else if (nb > 16)               tag = "R4 long frame uses first 16";
      else if (slot < 0)              tag = "R7 undefined address";
      else if (slot >= 5)             tag = "R8 test mask";
      else if (fr[1:0] != 2'b00)      tag = "R5 opcode ignored";
      else                            tag = "R1 R6 field decode";
      selN = 1'b0;
      waitCyc(4);
      shiftBits(fr, nb);
      chk("R2 no strobe before release", {15'd0, wrStrobe}, 16'd0);
      selN = 1'b1;
      @(posedge clk); @(posedge clk); @(posedge clk);
      @(negedge clk);
      if (commit && slot >= 0) expReg[slot] = fr[15:6] & MAP_MASK[slot];
      chk({tag, " R2 R10 strobe"}, {15'd0, wrStrobe}, {15'd0, commit});
      @(negedge clk);
      chk("R10 strobe one cycle", {15'd0, wrStrobe}, 16'd0);
      chkRegs({tag, " R11"});
      waitCyc(4);
    end

    // R9: reset in the middle of a frame abandons it
    selN = 1'b0;
    waitCyc(4);
    shiftBits({10'h3FF, 4'd4, 2'b00}, 8);
    rstN = 1'b0;
    waitCyc(2);
    setDefaults();
    chkRegs("R9 async reset mid-frame");
    rstN = 1'b1;
    shiftBits({10'h3FF, 4'd4, 2'b00}, 8);
    selN = 1'b1;
    waitCyc(6);
    chk("R9 partial frame discarded, no strobe", {15'd0, wrStrobe}, 16'd0);
    chkRegs("R9 R3 partial frame discarded");

    // normal write still works after reset
    selN = 1'b0;
    waitCyc(4);
    shiftBits({10'h0AB, 4'd2, 2'b01}, 16);
    selN = 1'b1;
    waitCyc(6);
    expReg[4] = 10'h0AB;
    chkRegs("R6 write after reset");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule